// File: doc/BRIEF.md
# Divided Countdown Interrupt Timer

This block is the one-shot countdown timer of a per-core interrupt controller. It runs on the bus clock. A power-of-two prescaler sits in front of the down-counter, and its ratio is chosen by a sparse three-bit code. Software sets the prescaler code and then writes a start count. The timer counts down once per prescaler period. When the count reaches zero it sends a single-cycle pulse to the local priority logic and stops.

Software uses a simple register port. A write port loads the registers. A read port returns one register, one cycle after the select is presented. Four locations are decoded:

| Select | Register |
|---|---|
| 0 | Vector-table entry for the timer source |
| 1 | Prescaler configuration |
| 2 | Start count |
| 3 | Remaining count |

The vector-table entry is stored and returned as written, except for two status bits that software cannot change. The remaining count tells software how many whole prescaler periods are left, with any partly elapsed period counted as whole.

Top module: `cdt_timer_top`

## Requirements
- R1: The prescaler code is {cfg[3], cfg[1:0]}. The ratio is 1 << ((code + 1) mod 8), so code 7 gives ratio 1 and code 0 gives ratio 2. Writing start count N > 0 at clock edge k raises the interrupt after edge k + N*ratio.
- R2: A write to the prescaler configuration (select 1) keeps only bits 3, 1 and 0. A read of select 1 returns zero in every other bit.
- R3: A read of select 3 returns ceil(remaining clocks / ratio), which is the number of periods left with a partial period counted as whole. It returns 0 while the timer is idle. The read data is registered: a select presented before edge e shows the state from before edge e.
- R4: A write to select 3 is ignored. A running countdown keeps its original expiry.
- R5: In the vector-table entry (select 0), bits 12 and 14 keep their previous value on a write. All other bits take the written value.
- R6: Writing a start count of 0 stops the timer. No interrupt follows, and select 3 reads 0.
- R7: Writing a new start count while the timer is running restarts the countdown from the new value. The earlier expiry is dropped.
- R8: A prescaler configuration change made while counting does not shorten or lengthen the period in progress. The new ratio takes effect at the next prescaler rollover.
- R9: The interrupt is a pulse exactly one cycle wide, issued once per countdown.
- R10: Synchronous active-high reset clears all registers. After reset the timer is idle, the interrupt output is low, and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register select for the read |
| rd_data | output | 32 | Registered read data |
| irq_pulse | output | 1 | One-cycle expiry pulse |

## Verification
The assertions assume the following about the inputs:
- The selects are always driven to defined values.
- Writes come at most one per cycle.

No assumption is made about when writes occur relative to prescaler rollovers. The bench therefore issues configuration writes and count writes at arbitrary points inside a period, including immediately after a start. All stimulus is driven on the falling clock edge, so every write lands on a known rising edge. The bench then works out the expected expiry cycle and the expected readback from that edge alone.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [1:0] {
    SEL_VEC  = 2'd0,
    SEL_DIV  = 2'd1,
    SEL_INIT = 2'd2,
    SEL_CUR  = 2'd3
  } reg_sel_e;

  // rotate-by-one mapping from sparse code to shift amount
  function automatic logic [CODE_W-1:0] code_to_shift(input logic [CODE_W-1:0] code);
    return code + {{(CODE_W-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/cdt_regs.sv
module cdt_regs #(
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 32,
  parameter int CODE_W   = 3,
  parameter logic [DATA_W-1:0] DIV_MASK = 32'h0000_000B,
  parameter logic [DATA_W-1:0] VEC_RO   = 32'h0000_5000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] vec_q,
  output logic [DATA_W-1:0] div_q,
  output logic [CNT_W-1:0]  init_q,
  output logic [CODE_W-1:0] div_code,
  output logic              load,
  output logic [CNT_W-1:0]  load_val
);
  import cdt_pkg::*;

  logic wr_vec, wr_div;
  assign wr_vec   = wr_en && (wr_sel == SEL_VEC);
  assign wr_div   = wr_en && (wr_sel == SEL_DIV);
  assign load     = wr_en && (wr_sel == SEL_INIT);
  assign load_val = wr_data[CNT_W-1:0];
  assign div_code = {div_q[3], div_q[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q  <= '0;
      div_q  <= '0;
      init_q <= '0;
    end else begin
      if (wr_vec) vec_q  <= (wr_data & ~VEC_RO) | (vec_q & VEC_RO);
      if (wr_div) div_q  <= wr_data & DIV_MASK;
      if (load)   init_q <= load_val;
    end
  end

  assert_vec_status_kept_R5: assert property (@(posedge clk) disable iff (rst)
    wr_vec |=> ((vec_q & VEC_RO) == ($past(vec_q) & VEC_RO)));
endmodule

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              run,
  input  logic [CODE_W-1:0] div_code,
  output logic              roll
);
  import cdt_pkg::*;

  localparam int PRE_W = 2 ** CODE_W;

  logic [PRE_W-1:0]  pre_q;
  logic [CODE_W-1:0] shift_q;
  logic [PRE_W-1:0]  ratio_m1;

  assign ratio_m1 = (PRE_W'(1) << shift_q) - PRE_W'(1);
  assign roll     = run && (pre_q == ratio_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q   <= '0;
      shift_q <= '0;
    end else if (load || roll) begin
      // ratio is sampled only at a start or a period boundary
      pre_q   <= '0;
      shift_q <= code_to_shift(div_code);
    end else if (run) begin
      pre_q   <= pre_q + PRE_W'(1);
    end else begin
      pre_q   <= '0;
    end
  end

  assert_pre_in_range_R8: assert property (@(posedge clk) disable iff (rst)
    pre_q <= ratio_m1);
  assert_ratio_held_R8: assert property (@(posedge clk) disable iff (rst)
    (!load && !roll) |=> $stable(shift_q));
endmodule

// File: rtl/cdt_down_counter.sv
module cdt_down_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             roll,
  output logic             run,
  output logic [CNT_W-1:0] remain,
  output logic             irq
);
  logic [CNT_W-1:0] remain_q;
  logic             irq_q;

  assign run    = (remain_q != '0);
  assign remain = remain_q;
  assign irq    = irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= roll && (remain_q == CNT_W'(1)) && !load;
      if (load)
        remain_q <= load_val;
      else if (roll && run)
        remain_q <= remain_q - CNT_W'(1);
    end
  end

  assert_irq_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);
  assert_hold_between_steps_R1: assert property (@(posedge clk) disable iff (rst)
    (!load && !roll) |=> (remain_q == $past(remain_q)));
  assert_idle_no_irq_R6: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> !irq_q);
endmodule

// File: rtl/cdt_timer_top.sv
module cdt_timer_top #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int CODE_W = cdt_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_pulse
);
  import cdt_pkg::*;

  logic [DATA_W-1:0] vec_q, div_q;
  logic [CNT_W-1:0]  init_q, load_val, remain;
  logic [CODE_W-1:0] div_code;
  logic              load, roll, run;
  logic [DATA_W-1:0] rd_q;

  cdt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .CODE_W(CODE_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .vec_q(vec_q), .div_q(div_q), .init_q(init_q), .div_code(div_code),
    .load(load), .load_val(load_val)
  );

  cdt_prescaler #(.CODE_W(CODE_W)) pre_i (
    .clk(clk), .rst(rst), .load(load), .run(run), .div_code(div_code), .roll(roll)
  );

  cdt_down_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .roll(roll),
    .run(run), .remain(remain), .irq(irq_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      case (rd_sel)
        SEL_VEC:  rd_q <= vec_q;
        SEL_DIV:  rd_q <= div_q;
        SEL_INIT: rd_q <= DATA_W'(init_q);
        default:  rd_q <= DATA_W'(remain);
      endcase
    end
  end
  assign rd_data = rd_q;

  assert_div_readback_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == SEL_DIV) |=> ((rd_data & ~DATA_W'(32'hB)) == '0));
  assert_idle_reads_zero_R3: assert property (@(posedge clk) disable iff (rst)
    ((rd_sel == SEL_CUR) && !run) |=> (rd_data == '0));
endmodule

// File: tb/cdt_timer_top_tb_top.sv
module cdt_timer_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd3;
  logic [31:0] rd_data;
  logic        irq_pulse;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cdt_timer_top dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq_pulse(irq_pulse)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // write lands on the next rising edge; returns just after that edge
  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] val);
    @(negedge clk);
    rd_sel = sel;
    @(posedge clk);
    @(negedge clk);
    val = rd_data;
    rd_sel = 2'd3;
  endtask

  function automatic int ratio_of(input int code);
    return 1 << ((code + 1) % 8);
  endfunction

  // R1 R3 R9: start count n with prescaler code c, follow it cycle by cycle
  task automatic run_one(input int code, input int n);
    int r, total, s;
    logic [31:0] exp_rd;
    r = ratio_of(code);
    total = n * r;
    wr(2'd1, 32'hFFF0_0004 | ((code & 4) << 1) | (code & 3));
    rd_sel = 2'd3;
    wr(2'd2, n);
    for (int t = 1; t <= total + 2; t++) begin
      @(posedge clk);
      @(negedge clk);
      chk(irq_pulse == (t == total), "R1/R9 expiry cycle", {31'd0, irq_pulse}, {31'd0, t == total});
      s = t - 1;
      exp_rd = (s < total) ? (total - s + r - 1) / r : 0;
      chk(rd_data == exp_rd, "R3 remaining count", rd_data, exp_rd);
    end
  endtask

  task automatic expect_irq_at(input int first_t, input int last_t, input int hit, input string req);
    for (int t = first_t; t <= last_t; t++) begin
      @(posedge clk);
      @(negedge clk);
      chk(irq_pulse == (t == hit), req, {31'd0, irq_pulse}, {31'd0, t == hit});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R10: reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk(v == 32'd0, "R10 reset readback", v, 32'd0);
    end
    chk(irq_pulse == 1'b0, "R10 reset irq", {31'd0, irq_pulse}, 32'd0);

    // R2: prescaler configuration mask
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v);
    chk(v == 32'h0000_000B, "R2 cfg mask", v, 32'h0000_000B);
    wr(2'd1, 32'h0000_0004);
    rd(2'd1, v);
    chk(v == 32'd0, "R2 cfg bit2 dropped", v, 32'd0);

    // R5: vector-table status bits
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v);
    chk(v == 32'hFFFF_AFFF, "R5 vec write all ones", v, 32'hFFFF_AFFF);
    wr(2'd0, 32'h0001_2345);
    rd(2'd0, v);
    chk(v == 32'h0001_2345 & ~32'h5000, "R5 vec pattern", v, 32'h0001_2345 & ~32'h5000);

    // R1 R3 R9: sweep every prescaler code with small counts
    for (int c = 0; c < 8; c++)
      for (int n = 1; n <= 3; n++)
        run_one(c, n);

    // R6: zero start count stops the timer
    wr(2'd1, 32'h0);
    wr(2'd2, 50);
    repeat (10) @(posedge clk);
    wr(2'd2, 0);
    rd_sel = 2'd3;
    for (int t = 1; t <= 200; t++) begin
      @(posedge clk);
      @(negedge clk);
      chk(irq_pulse == 1'b0, "R6 no irq after stop", {31'd0, irq_pulse}, 32'd0);
    end
    chk(rd_data == 32'd0, "R6 remaining zero", rd_data, 32'd0);

    // R7: restart while running (ratio 1)
    wr(2'd1, 32'h0000_000B);
    wr(2'd2, 100);
    repeat (20) @(posedge clk);
    wr(2'd2, 5);
    expect_irq_at(1, 120, 5, "R7 restart expiry");

    // R4: write to remaining count ignored (ratio 1, start at edge k, write at k+1)
    wr(2'd2, 30);
    wr(2'd3, 32'd7);
    expect_irq_at(2, 36, 30, "R4 remaining read-only");

    // R8: ratio 4 start, switch to ratio 2 one edge later; expiry at 4+2+2
    wr(2'd1, 32'h0000_0001);
    wr(2'd2, 3);
    wr(2'd1, 32'h0000_0000);
    expect_irq_at(2, 14, 8, "R8 deferred ratio change");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule